// File: doc/BRIEF.md
# Low-Voltage Reset Generator with Oscillator Startup Hold

This block produces the internal chip reset from two sources: an active-low external reset pin and a supply-low flag from an analog comparator. The flag is synchronous to the system clock. A supply-low condition counts only after it has stayed high without a break for more than a set number of slow reference ticks, about 1 ms. Shorter dips are filtered out.

The qualified supply-low reset and the synchronized external pin are ORed together. When every source has gone away, a startup timer keeps the chip in reset for a fixed number of system clocks so the oscillator can settle. The filter length and the hold length are parameters. At a 4 MHz system clock, the nominal hold is 1024 clocks.

Top module: `lvr_reset_gen`

## Requirements
- R1: A supply-low interval in which `lv_flag` stays high through at most `FILT_TICKS` cycles that carry `tick` high causes no reset. `chip_rst_n` stays 1.
- R2: When `lv_flag` stays high through `FILT_TICKS`+1 tick cycles, `chip_rst_n` goes to 0 and stays 0 while `lv_flag` remains high.
- R3: `chip_rst_n` is 0 whenever either the external pin or the qualified supply-low condition is active. Driving `ext_rst_n` low forces `chip_rst_n` to 0 at once, without waiting for a clock edge.
- R4: After the qualified supply-low condition ends, `chip_rst_n` returns to 1 on exactly the `HOLD_CYCLES`+1-th rising clock edge after `lv_flag` is first sampled low. One edge clears the qualifier and `HOLD_CYCLES` edges form the hold.
- R5: The tick count clears whenever `lv_flag` is sampled low, so only one unbroken high interval is measured. Ticks that arrive while `lv_flag` is low are not counted.
- R6: If any reset source reasserts during the hold, the hold restarts from zero.
- R7: Release of `ext_rst_n` passes through a two-stage synchronizer. With no supply-low condition, `chip_rst_n` returns to 1 on exactly the `HOLD_CYCLES`+2-th rising edge after `ext_rst_n` rises.

Timing for R4 and R7 is counted with `lv_flag`, `tick` and `ext_rst_n` changed between clock edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous |
| tick | input | 1 | One-cycle pulse of the slow reference used to time the filter |
| lv_flag | input | 1 | Supply-low flag from the comparator, synchronous to clk, 1 = low supply |
| chip_rst_n | output | 1 | Internal chip reset, active low |

## Verification
The hardest situations to reach are the two edges of the filter threshold. One is a low interval that holds for exactly `FILT_TICKS` ticks and must be ignored. The other holds for one tick more and must reset. A third is a pair of sub-threshold intervals split by a single low cycle, which must not add up. The bench shapes each interval directly: it places one-cycle tick pulses while holding `lv_flag` high, and it watches `chip_rst_n` on every cycle of the interval rather than only at its end. Restart of the hold is reached by pulsing the external pin partway through a running hold and timing the next release edge by edge.

// File: rtl/lvr_pkg.sv
// Package lvr_pkg
// Shared types for the low-voltage reset generator.
// Assumes: nothing beyond IEEE 1800-2017.
package lvr_pkg;
    // State of the startup hold timer
    typedef enum logic {
        HS_HOLD = 1'b0,
        HS_RUN  = 1'b1
    } hold_state_t;
endpackage

// File: rtl/lvr_ext_sync.sv
// Module lvr_ext_sync
// Synchronizes the external reset pin. Assertion clears the chain at once;
// release ripples through STAGES flops, so it is synchronous to clk.
// Assumes: STAGES >= 2. This is the only asynchronously reset logic in the block.
module lvr_ext_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic ext_rst_n,
    output logic sync_n
);
    logic [STAGES-1:0] chain;

    // Shift ones in after release, clear everything on assertion
    always_ff @(posedge clk or negedge ext_rst_n) begin
        if (!ext_rst_n) chain <= '0;
        else            chain <= {chain[STAGES-2:0], 1'b1};
    end

    assign sync_n = chain[STAGES-1];

    // R7
    sync_release_chk: assert property (@(posedge clk) disable iff (!ext_rst_n)
        $rose(sync_n) |-> $past(ext_rst_n));
endmodule

// File: rtl/lvr_glitch_filter.sv
// Module lvr_glitch_filter
// Qualifies the supply-low flag. It counts tick pulses during one unbroken
// high interval of lv_flag and raises lv_qual on tick number FILT_TICKS+1.
// Assumes: lv_flag and tick are synchronous to clk; tick is a one-cycle pulse.
module lvr_glitch_filter #(
    parameter int FILT_TICKS = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic lv_flag,
    output logic lv_qual
);
    localparam int CW = $clog2(FILT_TICKS + 1);
    localparam logic [CW-1:0] LIMIT = CW'(FILT_TICKS);

    logic [CW-1:0] cnt;

    // Count ticks while the flag holds; clear at once when it drops
    always_ff @(posedge clk) begin
        if (!rst_n || !lv_flag) begin
            cnt     <= '0;
            lv_qual <= 1'b0;
        end else if (tick) begin
            if (cnt == LIMIT) lv_qual <= 1'b1;
            else              cnt     <= cnt + 1'b1;
        end
    end

    // R2
    qual_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lv_qual) |-> $past(lv_flag && tick));
    // R5
    flag_drop_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lv_flag |=> !lv_qual);
endmodule

// File: rtl/lvr_hold_timer.sv
// Module lvr_hold_timer
// Startup hold. While src is active the timer is held at zero. Once src
// clears, it counts HOLD_CYCLES clocks and then raises done.
// Assumes: HOLD_CYCLES >= 2; src is synchronous to clk.
module lvr_hold_timer
    import lvr_pkg::*;
#(
    parameter int HOLD_CYCLES = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic src,
    output logic done
);
    localparam int HW = $clog2(HOLD_CYCLES + 1);
    localparam logic [HW-1:0] LAST = HW'(HOLD_CYCLES - 1);

    hold_state_t   state;
    logic [HW-1:0] cnt;

    // Restart on any source, otherwise count toward release
    always_ff @(posedge clk) begin
        if (!rst_n || src) begin
            state <= HS_HOLD;
            cnt   <= '0;
        end else if (state == HS_HOLD) begin
            if (cnt == LAST) state <= HS_RUN;
            else             cnt   <= cnt + 1'b1;
        end
    end

    assign done = (state == HS_RUN);

    // R6
    src_restarts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        src |=> !done);
    // R4
    release_after_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(!src));
endmodule

// File: rtl/lvr_reset_gen.sv
// Module lvr_reset_gen
// Top of the reset generator. It ORs the synchronized external pin with the
// filtered supply-low flag and holds the result through the startup timer.
// The external pin also gates the output directly, so its assertion does not
// wait for a clock edge.
// Assumes: lv_flag and tick are synchronous to clk.
module lvr_reset_gen #(
    parameter int FILT_TICKS  = 32,
    parameter int HOLD_CYCLES = 1024,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic ext_rst_n,
    input  logic tick,
    input  logic lv_flag,
    output logic chip_rst_n
);
    logic ext_ok;
    logic lv_qual;
    logic hold_done;

    lvr_ext_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .ext_rst_n (ext_rst_n),
        .sync_n    (ext_ok)
    );

    lvr_glitch_filter #(.FILT_TICKS(FILT_TICKS)) u_filt (
        .clk     (clk),
        .rst_n   (ext_ok),
        .tick    (tick),
        .lv_flag (lv_flag),
        .lv_qual (lv_qual)
    );

    lvr_hold_timer #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
        .clk   (clk),
        .rst_n (ext_ok),
        .src   (lv_qual),
        .done  (hold_done)
    );

    // Chip runs only when the pin is released and the hold has finished
    assign chip_rst_n = hold_done & ext_ok;

    // R2
    qual_forces_reset_chk: assert property (@(posedge clk) disable iff (!ext_ok)
        lv_qual |=> !chip_rst_n);
    // R3
    pin_forces_reset_chk: assert property (@(negedge clk)
        !ext_rst_n |-> !chip_rst_n);
endmodule

// File: tb/tb_lvr_reset_gen.sv
module tb_lvr_reset_gen;
    localparam int FILT = 6;
    localparam int HOLD = 40;

    logic clk = 1'b0;
    logic ext_rst_n;
    logic tick;
    logic lv_flag;
    logic chip_rst_n;
    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    lvr_reset_gen #(.FILT_TICKS(FILT), .HOLD_CYCLES(HOLD)) dut (
        .clk(clk), .ext_rst_n(ext_rst_n), .tick(tick),
        .lv_flag(lv_flag), .chip_rst_n(chip_rst_n)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s chip_rst_n actual %0b expected %0b", req, act, exp);
        end
    endtask

    task automatic check_int(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Counts rising edges until chip_rst_n reads 1 at a falling edge
    task automatic edges_to_release(output int n);
        n = 0;
        while (n < 4 * HOLD) begin
            @(posedge clk); n++;
            @(negedge clk);
            if (chip_rst_n) break;
        end
    endtask

    // Pulses tick k times with the flag high; returns whether reset was ever seen
    task automatic ticks_high(input int k, output logic seen_rst);
        seen_rst = 1'b0;
        lv_flag = 1'b1;
        for (int i = 0; i < k; i++) begin
            tick = 1'b1; @(negedge clk); tick = 1'b0;
            if (!chip_rst_n) seen_rst = 1'b1;
            repeat (2) begin @(negedge clk); if (!chip_rst_n) seen_rst = 1'b1; end
        end
    endtask

    task automatic t_reset;
        int n;
        ext_rst_n = 1'b0; tick = 1'b0; lv_flag = 1'b0;
        repeat (3) @(negedge clk);
        check("R3 reset state", chip_rst_n, 1'b0);
        ext_rst_n = 1'b1;
        edges_to_release(n);
        check_int("R7 pin release edges", n, HOLD + 2);
    endtask

    task automatic t_dip_below;
        logic seen;
        ticks_high(FILT, seen);
        lv_flag = 1'b0;
        repeat (4) begin @(negedge clk); if (!chip_rst_n) seen = 1'b1; end
        check("R1 dip of FILT ticks", seen, 1'b0);
    endtask

    task automatic t_dip_above;
        logic seen;
        int n;
        ticks_high(FILT + 1, seen);
        repeat (2) @(negedge clk);
        check("R2 FILT+1 ticks", chip_rst_n, 1'b0);
        ticks_high(3, seen);
        check("R2 held while flag high", chip_rst_n, 1'b0);
        lv_flag = 1'b0;
        edges_to_release(n);
        check_int("R4 release edges after flag drop", n, HOLD + 1);
    endtask

    task automatic t_split;
        logic s1, s2;
        ticks_high(FILT, s1);
        lv_flag = 1'b0; @(negedge clk);
        ticks_high(FILT, s2);
        lv_flag = 1'b0;
        repeat (3) @(negedge clk);
        check("R5 split interval no reset", s1 | s2 | !chip_rst_n, 1'b0);
    endtask

    task automatic t_low_ticks;
        logic seen;
        lv_flag = 1'b0;
        for (int i = 0; i < 10; i++) begin
            tick = 1'b1; @(negedge clk); tick = 1'b0; @(negedge clk);
        end
        ticks_high(FILT, seen);
        lv_flag = 1'b0;
        repeat (3) @(negedge clk);
        check("R5 ticks while flag low ignored", seen | !chip_rst_n, 1'b0);
    endtask

    task automatic t_async;
        int n;
        ext_rst_n = 1'b0;
        #1;
        check("R3 asynchronous assertion", chip_rst_n, 1'b0);
        @(negedge clk); ext_rst_n = 1'b1;
        edges_to_release(n);
        check_int("R7 release after async", n, HOLD + 2);
    endtask

    task automatic t_restart;
        int n;
        ext_rst_n = 1'b0; @(negedge clk); ext_rst_n = 1'b1;
        repeat (HOLD / 2) @(negedge clk);
        check("R6 still in hold", chip_rst_n, 1'b0);
        ext_rst_n = 1'b0; repeat (2) @(negedge clk); ext_rst_n = 1'b1;
        edges_to_release(n);
        check_int("R6 hold restarted", n, HOLD + 2);
    endtask

    task automatic t_or;
        logic seen;
        int n;
        ticks_high(FILT + 1, seen);
        repeat (2) @(negedge clk);
        check("R2 qualified before pin", chip_rst_n, 1'b0);
        ext_rst_n = 1'b0; @(negedge clk);
        lv_flag = 1'b0; repeat (3) @(negedge clk);
        check("R3 pin keeps reset after flag drop", chip_rst_n, 1'b0);
        ext_rst_n = 1'b1;
        edges_to_release(n);
        check_int("R3 OR release follows pin", n, HOLD + 2);
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        ext_rst_n = 1'b0; tick = 1'b0; lv_flag = 1'b0;
        @(negedge clk);
        t_reset();
        t_dip_below();
        t_dip_above();
        t_split();
        t_low_ticks();
        t_async();
        t_restart();
        t_or();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule